// File: doc/BRIEF.md
# Memory-Indirect OR Execution Unit

This block executes the logical-OR instructions of a narrow-data microcontroller core that take a memory operand. The core holds a 4-bit data register pair (A, B) and a 16-bit index register pair (X, Y). This unit sits next to that register file. It decodes a 13-bit opcode and reads the register values it needs from the file. It then drives write strobes back into the file, into the zero flag and into the extension flag. It also drives a data-memory port whose read data is valid in the same cycle as the address and whose writes take effect at the clock edge.

The unit has two instruction forms:

- **Register destination.** The memory operand is ORed into a data register and the index is then incremented. This form finishes in the cycle the opcode is accepted.
- **Memory destination.** A data register is ORed into memory by a read-modify-write. The read happens in the accept cycle and the write-back in the following cycle. If an extension byte is pending, this form addresses a fixed 256-byte page chosen by the index register in the opcode, and the index register itself is left untouched.

Opcodes arrive on a valid/ready handshake. An opcode is taken on a cycle where `op_valid` and `op_ready` are both high. `op_ready` is low only during a write-back cycle. While `op_ready` is low, the issuer must hold `opcode` and the extension inputs stable. All other pins are plain strobes that last a single cycle.

Top module: `or_exec_unit`

## Requirements
- R1: `op_ready` is high in every cycle except the write-back cycle of a memory-destination instruction. An opcode is accepted only when `op_valid` and `op_ready` are both high.
- R2: Opcodes 1B61H, 1B63H, 1B65H and 1B67H are the register-destination form. Opcode bit 1 selects the index (0 = X, 1 = Y) and bit 2 selects the data register (0 = A, 1 = B). In the accept cycle the unit asserts `mem_rd` with `mem_addr` equal to the index, and writes register OR `mem_rdata` into the selected register (`reg_sel` 0 = A, 1 = B). `done` is asserted in that same cycle.
- R3: The register-destination form writes index + 1 to the selected index (`idx_sel` 0 = X, 1 = Y), wrapping from FFFFH to 0000H.
- R4: The register-destination form ignores `ext_pending` and `ext_imm`. The address is always the index register.
- R5: Opcodes 1B68H, 1B6AH, 1B6CH and 1B6EH are the memory-destination form, using the same bit 1 and bit 2 selection. The unit reads in the accept cycle. In the next cycle it asserts `mem_wr` at the same address, with memory OR register as the data, and asserts `done`. It writes no data register.
- R6: With `ext_pending` high, the memory-destination form addresses 0000H + `ext_imm` when X is selected and FF00H + `ext_imm` when Y is selected. No index register is written.
- R7: `z_we` accompanies the completion of every recognised instruction, with `z_val` high exactly when the OR result is zero. No other flag is written by the unit.
- R8: `ext_clr` is asserted together with `done` on completion of every recognised instruction.
- R9: Any other opcode asserts `illegal` and `done` in its accept cycle, with no register, index, flag, extension-clear or memory write.
- R10: While reset (`rst_n` low) is applied, `op_ready` is high and `done`, `mem_wr`, `reg_we` and `idx_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode present |
| op_ready | output | 1 | Unit can take an opcode this cycle |
| opcode | input | 13 | Instruction code |
| ext_pending | input | 1 | An extension byte precedes this instruction |
| ext_imm | input | 8 | Pending extension byte |
| reg_a | input | 4 | Current value of data register A |
| reg_b | input | 4 | Current value of data register B |
| idx_x | input | 16 | Current value of index register X |
| idx_y | input | 16 | Current value of index register Y |
| mem_addr | output | 16 | Data-memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 4 | Memory read data, valid in the same cycle as `mem_addr` |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 4 | Memory write data |
| reg_we | output | 1 | Data register write strobe |
| reg_sel | output | 1 | Data register select, 0 = A, 1 = B |
| reg_wdata | output | 4 | Data register write value |
| idx_we | output | 1 | Index register write strobe |
| idx_sel | output | 1 | Index select, 0 = X, 1 = Y |
| idx_wdata | output | 16 | Index write value |
| z_we | output | 1 | Zero flag write strobe |
| z_val | output | 1 | Zero flag value |
| ext_clr | output | 1 | Clear the extension flag |
| done | output | 1 | Final cycle of an instruction |
| illegal | output | 1 | Unrecognised opcode |

## Verification
The only internal state is the write-back flag together with the latched address and data. A wrong value in any of them shows at the ports one cycle after a memory-destination accept. It appears as a stuck-low `op_ready`, a write to the wrong address or with the wrong data, or a missing `done`. A decode or address-selection fault shows in the accept cycle itself, as a wrong `mem_addr`, a wrong register or index strobe, or a flag strobe on an illegal code. The bench therefore samples every strobe in both cycles of each instruction, and also samples the idle cycle that follows.

// File: rtl/or_exec_pkg.sv
package or_exec_pkg;
  localparam int OP_W = 13;

  localparam logic [OP_W-1:0] POSTINC_BASE = 13'h1B61;
  localparam logic [OP_W-1:0] RMW_BASE     = 13'h1B68;
  localparam logic [OP_W-1:0] SEL_MASK     = 13'h0006;
  localparam int IDX_BIT = 1;
  localparam int REG_BIT = 2;

  typedef enum logic [1:0] {
    KIND_ILLEGAL = 2'd0,
    KIND_POSTINC = 2'd1,
    KIND_RMW     = 2'd2
  } op_kind_e;

  typedef struct packed {
    op_kind_e kind;
    logic     use_y;
    logic     use_b;
  } op_dec_t;

  function automatic op_dec_t decode_op(logic [OP_W-1:0] op);
    op_dec_t d;
    logic [OP_W-1:0] base;
    base    = op & ~SEL_MASK;
    d.use_y = op[IDX_BIT];
    d.use_b = op[REG_BIT];
    if (base == POSTINC_BASE)  d.kind = KIND_POSTINC;
    else if (base == RMW_BASE) d.kind = KIND_RMW;
    else                       d.kind = KIND_ILLEGAL;
    return d;
  endfunction
endpackage

// File: rtl/or_op_decode.sv
module or_op_decode
  import or_exec_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output op_dec_t         dec
);
  always_comb dec = decode_op(opcode);
endmodule

// File: rtl/or_addr_gen.sv
module or_addr_gen
  import or_exec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int EXT_W  = 8
) (
  input  op_kind_e          kind,
  input  logic              use_y,
  input  logic              ext_pending,
  input  logic [EXT_W-1:0]  ext_imm,
  input  logic [ADDR_W-1:0] idx_x,
  input  logic [ADDR_W-1:0] idx_y,
  output logic [ADDR_W-1:0] cur_idx,
  output logic [ADDR_W-1:0] eff_addr
);
  localparam int PAGE_W = ADDR_W - EXT_W;

  logic [ADDR_W-1:0] paged;

  generate
    if (PAGE_W > 0) begin : g_page
      logic [PAGE_W-1:0] page_hi;
      always_comb page_hi = use_y ? {PAGE_W{1'b1}} : {PAGE_W{1'b0}};
      always_comb paged = {page_hi, ext_imm};
    end else begin : g_nopage
      always_comb paged = ext_imm[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    cur_idx  = use_y ? idx_y : idx_x;
    eff_addr = cur_idx;
    if (kind == KIND_RMW && ext_pending) eff_addr = paged;
  end
endmodule

// File: rtl/or_wb_seq.sv
module or_wb_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_rmw,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] merged,
  output logic              in_wb,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_wb   <= 1'b0;
      wb_addr <= '0;
      wb_data <= '0;
    end else begin
      in_wb <= start_rmw;
      if (start_rmw) begin
        wb_addr <= rd_addr;
        wb_data <= merged;
      end
    end
  end

  assert_wb_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_wb |=> !in_wb);
  assert_wb_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_rmw |=> in_wb);
  assert_wb_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_wb |-> wb_addr == $past(rd_addr));
endmodule

// File: rtl/or_exec_unit.sv
module or_exec_unit
  import or_exec_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 16,
  parameter int EXT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [OP_W-1:0]   opcode,
  input  logic              ext_pending,
  input  logic [EXT_W-1:0]  ext_imm,
  input  logic [DATA_W-1:0] reg_a,
  input  logic [DATA_W-1:0] reg_b,
  input  logic [ADDR_W-1:0] idx_x,
  input  logic [ADDR_W-1:0] idx_y,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              reg_we,
  output logic              reg_sel,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              idx_we,
  output logic              idx_sel,
  output logic [ADDR_W-1:0] idx_wdata,
  output logic              z_we,
  output logic              z_val,
  output logic              ext_clr,
  output logic              done,
  output logic              illegal
);
  op_dec_t           dec;
  logic              accept;
  logic              in_wb;
  logic              start_rmw;
  logic [ADDR_W-1:0] cur_idx;
  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-1:0] wb_addr;
  logic [DATA_W-1:0] wb_data;
  logic [DATA_W-1:0] cur_reg;
  logic [DATA_W-1:0] or_res;
  logic              is_post;

  or_op_decode u_dec (
    .opcode (opcode),
    .dec    (dec)
  );

  or_addr_gen #(.ADDR_W(ADDR_W), .EXT_W(EXT_W)) u_addr (
    .kind        (dec.kind),
    .use_y       (dec.use_y),
    .ext_pending (ext_pending),
    .ext_imm     (ext_imm),
    .idx_x       (idx_x),
    .idx_y       (idx_y),
    .cur_idx     (cur_idx),
    .eff_addr    (eff_addr)
  );

  or_wb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_rmw (start_rmw),
    .rd_addr   (eff_addr),
    .merged    (or_res),
    .in_wb     (in_wb),
    .wb_addr   (wb_addr),
    .wb_data   (wb_data)
  );

  always_comb begin
    op_ready  = !in_wb;
    accept    = op_valid && op_ready;
    is_post   = accept && dec.kind == KIND_POSTINC;
    start_rmw = accept && dec.kind == KIND_RMW;
    illegal   = accept && dec.kind == KIND_ILLEGAL;

    cur_reg = dec.use_b ? reg_b : reg_a;
    or_res  = mem_rdata | cur_reg;

    mem_addr  = in_wb ? wb_addr : eff_addr;
    mem_rd    = is_post || start_rmw;
    mem_wr    = in_wb;
    mem_wdata = wb_data;

    reg_we    = is_post;
    reg_sel   = dec.use_b;
    reg_wdata = or_res;

    idx_we    = is_post;
    idx_sel   = dec.use_y;
    idx_wdata = cur_idx + 1'b1;

    z_we    = is_post || in_wb;
    z_val   = in_wb ? (wb_data == '0) : (or_res == '0);
    ext_clr = z_we;
    done    = is_post || in_wb || illegal;
  end

  assert_ready_low_in_wb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !op_ready);
  assert_wb_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(op_valid && mem_rd));
  assert_wb_same_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_addr == $past(mem_addr));
  assert_postinc_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> mem_addr == (idx_sel ? idx_y : idx_x));
  assert_idx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we |-> idx_wdata == ADDR_W'(mem_addr + 1'b1));
  assert_no_idx_on_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !idx_we && !reg_we);
  assert_clr_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_clr |-> done && z_we);
  assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !(reg_we || idx_we || mem_wr || z_we || ext_clr || mem_rd));
endmodule

// File: tb/or_exec_unit_test.sv
`timescale 1ns/1ps
module or_exec_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [12:0] opcode = '0;
  logic        ext_pending = 1'b0;
  logic [7:0]  ext_imm = '0;
  logic [3:0]  reg_a = '0, reg_b = '0;
  logic [15:0] idx_x = '0, idx_y = '0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [3:0]  mem_rdata, mem_wdata;
  logic        reg_we, reg_sel, idx_we, idx_sel, z_we, z_val, ext_clr, done, illegal;
  logic [3:0]  reg_wdata;
  logic [15:0] idx_wdata;
  logic [3:0]  salt = 4'h0;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  function automatic logic [3:0] memf(logic [15:0] a, logic [3:0] s);
    return a[3:0] ^ a[7:4] ^ a[11:8] ^ a[15:12] ^ s;
  endfunction

  assign mem_rdata = memf(mem_addr, salt);

  or_exec_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .opcode(opcode), .ext_pending(ext_pending), .ext_imm(ext_imm),
    .reg_a(reg_a), .reg_b(reg_b), .idx_x(idx_x), .idx_y(idx_y),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .idx_we(idx_we), .idx_sel(idx_sel), .idx_wdata(idx_wdata),
    .z_we(z_we), .z_val(z_val), .ext_clr(ext_clr), .done(done), .illegal(illegal)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // 0 illegal, 1 register destination, 2 memory destination
  function automatic int classify(logic [12:0] op);
    if (op == 13'h1B61 || op == 13'h1B63 || op == 13'h1B65 || op == 13'h1B67) return 1;
    if (op == 13'h1B68 || op == 13'h1B6A || op == 13'h1B6C || op == 13'h1B6E) return 2;
    return 0;
  endfunction

  task automatic run_op(logic [12:0] op, logic [3:0] ra, logic [3:0] rb,
                        logic [15:0] ix, logic [15:0] iy, logic ep, logic [7:0] imm);
    int k;
    logic ysel, bsel;
    logic [15:0] idx, addr;
    logic [3:0] r, res;
    k = classify(op);
    ysel = op[1];
    bsel = op[2];
    idx = ysel ? iy : ix;
    r = bsel ? rb : ra;
    @(negedge clk);
    opcode = op; reg_a = ra; reg_b = rb; idx_x = ix; idx_y = iy;
    ext_pending = ep; ext_imm = imm; op_valid = 1'b1;
    #1;
    check("R1 ready at accept", {31'd0, op_ready}, 32'd1);
    if (k == 1) begin
      res = memf(idx, salt) | r;
      check("R2/R4 read addr", {15'd0, mem_rd, mem_addr}, {15'd0, 1'b1, idx});
      check("R2 reg write", {26'd0, reg_we, reg_sel, reg_wdata}, {26'd0, 1'b1, bsel, res});
      check("R3 index step", {14'd0, idx_we, idx_sel, idx_wdata}, {14'd0, 1'b1, ysel, idx + 16'd1});
      check("R7 zero flag", {30'd0, z_we, z_val}, {30'd0, 1'b1, res == 4'd0});
      check("R8 ext clear/done", {29'd0, ext_clr, done, mem_wr}, {29'd0, 3'b110});
      @(negedge clk);
      op_valid = 1'b0;
    end else if (k == 2) begin
      addr = ep ? {(ysel ? 8'hFF : 8'h00), imm} : idx;
      res = memf(addr, salt) | r;
      check("R5/R6 read addr", {15'd0, mem_rd, mem_addr}, {15'd0, 1'b1, addr});
      check("R5 quiet read cycle", {27'd0, reg_we, idx_we, done, mem_wr, z_we}, 32'd0);
      @(negedge clk);
      op_valid = 1'b0;
      #1;
      check("R1 ready low in write-back", {31'd0, op_ready}, 32'd0);
      check("R5 write-back", {11'd0, mem_wr, mem_addr, mem_wdata}, {11'd0, 1'b1, addr, res});
      check("R7 zero flag", {30'd0, z_we, z_val}, {30'd0, 1'b1, res == 4'd0});
      check("R8 ext clear/done", {30'd0, ext_clr, done}, 32'd3);
      check("R6 no index/reg write", {30'd0, reg_we, idx_we}, 32'd0);
      @(negedge clk);
    end else begin
      check("R9 illegal flagged", {30'd0, illegal, done}, 32'd3);
      check("R9 nothing written", {26'd0, reg_we, idx_we, mem_wr, z_we, ext_clr, mem_rd}, 32'd0);
      @(negedge clk);
      op_valid = 1'b0;
    end
    #1;
    check("R1 idle after", {30'd0, op_ready, done}, 32'd2);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] unused_seed;
    logic [12:0] legal [8];
    legal = '{13'h1B61, 13'h1B63, 13'h1B65, 13'h1B67, 13'h1B68, 13'h1B6A, 13'h1B6C, 13'h1B6E};
    unused_seed = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    #1;
    check("R10 reset state", {27'd0, op_ready, done, mem_wr, reg_we, idx_we}, {27'd0, 5'b10000});
    rst_n = 1'b1;
    // directed: every legal code once
    for (int i = 0; i < 8; i++) run_op(legal[i], 4'h5, 4'hA, 16'h1234, 16'h8001, 1'b0, 8'h00);
    // R3 wrap on X and Y
    run_op(13'h1B61, 4'h1, 4'h2, 16'hFFFF, 16'h0000, 1'b0, 8'h00);
    run_op(13'h1B63, 4'h1, 4'h2, 16'h0000, 16'hFFFF, 1'b0, 8'h00);
    // R4 extension ignored for register destination
    run_op(13'h1B65, 4'h3, 4'h4, 16'h4321, 16'h0F0F, 1'b1, 8'h77);
    // R6 paged write-back, X page and Y page
    run_op(13'h1B68, 4'h3, 4'h4, 16'h4321, 16'h0F0F, 1'b1, 8'h5C);
    run_op(13'h1B6E, 4'h3, 4'h4, 16'h4321, 16'h0F0F, 1'b1, 8'hC3);
    // R7 zero results
    salt = 4'h0;
    run_op(13'h1B61, 4'h0, 4'h0, 16'h0000, 16'h0000, 1'b0, 8'h00);
    run_op(13'h1B68, 4'h0, 4'h0, 16'h0000, 16'h0000, 1'b0, 8'h00);
    // R9 near-miss codes
    run_op(13'h1B60, 4'h1, 4'h1, 16'h0010, 16'h0020, 1'b0, 8'h00);
    run_op(13'h1B69, 4'h1, 4'h1, 16'h0010, 16'h0020, 1'b1, 8'h10);
    run_op(13'h1B6F, 4'h1, 4'h1, 16'h0010, 16'h0020, 1'b0, 8'h00);
    run_op(13'h0000, 4'h1, 4'h1, 16'h0010, 16'h0020, 1'b0, 8'h00);
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [12:0] op;
      salt = 4'($urandom);
      if ($urandom % 4 == 0) op = 13'($urandom);
      else op = legal[$urandom % 8];
      run_op(op, 4'($urandom % 3 == 0 ? 0 : $urandom), 4'($urandom),
             16'($urandom % 8 == 0 ? 16'hFFFF : $urandom), 16'($urandom),
             1'($urandom), 8'($urandom));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule